// File: doc/BRIEF.md
# Two-Channel Period/Duty Pulse-Width Modulator

The block drives two independent pulse-width modulated outputs from a single base clock. Each channel has a 32-bit period and a 32-bit duty value, both counted in whole base-clock ticks. A free-running counter per channel steps from 0 to period-1. The output is in its active state while the count is below the duty value.

One shared control word holds one byte per channel. Each byte carries an enable bit, a run-mode bit and an output-inversion bit. Software writes the registers through a simple single-cycle write port and reads them back through a combinational read port.

Period and duty writes land in staging registers. A running channel takes them up only at its next period boundary, so a waveform is never cut short in the middle of a period. Software is expected to keep the period at roughly one 108 ns interval or longer.

Top module: `dual_pwm_ctrl`

## Requirements
- R1: After reset, every register reads 0, both counters are 0 and both outputs are low.
- R2: Offset 0x00 holds the control word, with channel n's byte at bits 8n+7..8n. Channel n's period register is at 0x10+0x10*n and its duty register is at 0x14+0x10*n. Each of these registers reads back the last value written to it, and control-word bits 31..16 always read 0.
- R3: Any other offset, including one that is not word aligned, reads 0. A write to such an offset changes no register and no output.
- R4: A channel runs only when bit 0 (enable) and bit 7 (run mode) of its control byte are both 1.
- R5: A running channel with a nonzero period P counts 0..P-1 and then wraps. Its output is active while the count is below the duty value D, which gives D active cycles in every P.
- R6: Bit 4 of the control byte inverts the channel output. With bit 4 at 0 the active level is 1 and the idle level is 0; with bit 4 at 1 the active level is 0 and the idle level is 1.
- R7: A channel that is not running holds its counter at 0 and drives the idle level. When it starts, its first cycle is count 0.
- R8: When D is greater than or equal to a nonzero P, the output stays at the active level for the whole period.
- R9: A period of 0 keeps the output at the idle level.
- R10: While a channel runs, a new period or duty value takes effect at the next wrap to count 0. While a channel is not running, a new value takes effect at the next clock.
- R11: The two channels are fully independent. Writing one channel's registers has no effect on the other channel's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock; all counting is in its ticks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe, one write per cycle it is high |
| addr_i | input | 8 | Byte offset for the read and the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 2 | Channel outputs, bit n is channel n |

## Verification
The hardest case to reach is a period or duty write that lands while a channel is part way through a period. Its effect only shows one wrap later, and only if the old and new values give different waveforms. The stimulus writes a shorter period and then a larger duty into a channel that is mid-period, and writes one channel while the other is running. It also starts and stops channels at arbitrary counts. A cycle-accurate model in the bench follows every staging and reload step and compares both outputs on every clock.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int CTRL_BYTE_W   = 8;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INV_BIT  = 4;
  localparam int CTRL_MODE_BIT = 7;
  localparam int CTRL_OFS      = 'h00;
  localparam int CH_BASE       = 'h10;
  localparam int CH_STRIDE     = 'h10;
  localparam int DUTY_OFS      = 'h04;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_CH*CTRL_BYTE_W-1:0]     ctrl_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]     per_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]     duty_o
);
  localparam int CTRL_W = NUM_CH * CTRL_BYTE_W;

  logic              sel_ctrl;
  logic [NUM_CH-1:0] sel_per, sel_duty;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0][DATA_W-1:0] per_q, duty_q;

  assign sel_ctrl = (addr_i == ADDR_W'(CTRL_OFS));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign sel_per[n]  = (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * n));
    assign sel_duty[n] = (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * n + DUTY_OFS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (we_i) begin
      if (sel_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      for (int n = 0; n < NUM_CH; n++) begin
        if (sel_per[n])  per_q[n]  <= wdata_i;
        if (sel_duty[n]) duty_q[n] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) rdata_o = DATA_W'(ctrl_q);
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel_per[n])  rdata_o = per_q[n];
      if (sel_duty[n]) rdata_o = duty_q[n];
    end
  end

  assign ctrl_o = ctrl_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CTRL_BYTE_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0]      per_i,
  input  logic [DATA_W-1:0]      duty_i,
  output logic                   pwm_o,
  output logic [DATA_W-1:0]      cnt_o,
  output logic [DATA_W-1:0]      act_per_o,
  output logic [DATA_W-1:0]      act_duty_o
);
  logic run, inv, wrap, load, active;
  logic [DATA_W-1:0] cnt_q, act_per_q, act_duty_q;

  assign run  = ctrl_i[CTRL_EN_BIT] & ctrl_i[CTRL_MODE_BIT];
  assign inv  = ctrl_i[CTRL_INV_BIT];
  // zero period wraps every cycle so staged values keep flowing in
  assign wrap = (act_per_q == '0) || (cnt_q >= act_per_q - 1'b1);
  assign load = !run || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
    end else if (load) begin
      cnt_q      <= '0;
      act_per_q  <= per_i;
      act_duty_q <= duty_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active     = run && (act_per_q != '0) && (cnt_q < act_duty_q);
  assign pwm_o      = active ^ inv;
  assign cnt_o      = cnt_q;
  assign act_per_o  = act_per_q;
  assign act_duty_o = act_duty_q;
endmodule

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH*CTRL_BYTE_W-1:0] ctrl_w;
  logic [NUM_CH-1:0][DATA_W-1:0] per_w, duty_w, cnt_w, act_per_w, act_duty_w;

  dpwm_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .ctrl_o (ctrl_w),
    .per_o  (per_w),
    .duty_o (duty_w)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dpwm_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_i    (ctrl_w[n*CTRL_BYTE_W +: CTRL_BYTE_W]),
      .per_i     (per_w[n]),
      .duty_i    (duty_w[n]),
      .pwm_o     (pwm_o[n]),
      .cnt_o     (cnt_w[n]),
      .act_per_o (act_per_w[n]),
      .act_duty_o(act_duty_w[n])
    );
  end
endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             wdata_i,
  input logic [DATA_W-1:0]             rdata_o,
  input logic [NUM_CH-1:0]             pwm_o,
  input logic [NUM_CH*CTRL_BYTE_W-1:0] ctrl_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] per_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] duty_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] act_per_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] act_duty_i
);
  // R3
  misaligned_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00) |-> (rdata_o == '0));

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CTRL_OFS)) |-> (rdata_o[DATA_W-1:NUM_CH*CTRL_BYTE_W] == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    logic run, inv;
    assign run = ctrl_i[n*CTRL_BYTE_W + CTRL_EN_BIT] & ctrl_i[n*CTRL_BYTE_W + CTRL_MODE_BIT];
    assign inv = ctrl_i[n*CTRL_BYTE_W + CTRL_INV_BIT];

    // R2
    per_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(CH_BASE + CH_STRIDE * n)) |=> (per_i[n] == $past(wdata_i)));

    // R7
    idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> (pwm_o[n] == inv));

    // R7
    idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && $past(!run)) |-> (cnt_i[n] == '0));

    // R5
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_per_i[n] != '0) |-> (cnt_i[n] < act_per_i[n]));

    // R8
    full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && act_per_i[n] != '0 && act_duty_i[n] >= act_per_i[n]) |-> (pwm_o[n] == !inv));

    // R9
    zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_per_i[n] == '0) |-> (pwm_o[n] == inv));

    // R10
    mid_period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt_i[n] != '0) |-> ($stable(act_per_i[n]) && $stable(act_duty_i[n])));
  end
endmodule

bind dual_pwm_ctrl dpwm_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pwm_o     (pwm_o),
  .ctrl_i    (ctrl_w),
  .per_i     (per_w),
  .duty_i    (duty_w),
  .cnt_i     (cnt_w),
  .act_per_i (act_per_w),
  .act_duty_i(act_duty_w)
);

// File: tb/dual_pwm_ctrl_bench.sv
module dual_pwm_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  pwm_o;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    done   = 1'b0;

  dual_pwm_ctrl u_dual_pwm_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .pwm_o  (pwm_o)
  );

  always #4 clk_i = ~clk_i;

  // behavioural reference
  logic [15:0]  m_ctrl;
  longint       m_per[2], m_duty[2], m_ap[2], m_ad[2], m_cnt[2];

  function automatic bit m_run(int ch);
    return m_ctrl[8*ch] && m_ctrl[8*ch+7];
  endfunction

  function automatic bit m_out(int ch);
    bit act;
    act = m_run(ch) && m_ap[ch] != 0 && m_cnt[ch] < m_ad[ch];
    return act ^ m_ctrl[8*ch+4];
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a == 0) return {16'h0, m_ctrl};
    for (int ch = 0; ch < 2; ch++) begin
      if (a == 16 + 16*ch) return m_per[ch][31:0];
      if (a == 20 + 16*ch) return m_duty[ch][31:0];
    end
    return 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = '0;
      for (int ch = 0; ch < 2; ch++) begin
        m_per[ch] = 0; m_duty[ch] = 0; m_ap[ch] = 0; m_ad[ch] = 0; m_cnt[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (!m_run(ch) || m_ap[ch] == 0 || m_cnt[ch] + 1 >= m_ap[ch]) begin
          m_cnt[ch] = 0; m_ap[ch] = m_per[ch]; m_ad[ch] = m_duty[ch];
        end else begin
          m_cnt[ch] = m_cnt[ch] + 1;
        end
      end
      if (we_i) begin
        if (addr_i == 8'h00) m_ctrl = wdata_i[15:0];
        for (int ch = 0; ch < 2; ch++) begin
          if (addr_i == 8'(16 + 16*ch)) m_per[ch]  = longint'(wdata_i);
          if (addr_i == 8'(20 + 16*ch)) m_duty[ch] = longint'(wdata_i);
        end
      end
    end
  end

  // per-clock output comparison
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      for (int ch = 0; ch < 2; ch++) begin
        checks++;
        if (pwm_o[ch] !== m_out(ch)) begin
          errors++;
          $display("FAIL %s ch%0d pwm actual=%0b expected=%0b", phase, ch, pwm_o[ch], m_out(ch));
        end
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    #1;
    chk(tag, longint'(rdata_o), longint'(m_read(int'(a))));
  endtask

  task automatic count_level(int ch, int n, bit lvl, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (pwm_o[ch] == lvl) hits++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired in phase %s", phase);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hits;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    phase = "R1";
    rd(8'h00, "R1 ctrl"); rd(8'h10, "R1 per0"); rd(8'h14, "R1 duty0");
    rd(8'h20, "R1 per1"); rd(8'h24, "R1 duty1");
    chk("R1 pwm", longint'(pwm_o), 0);

    // R2: map and readback
    phase = "R2";
    wr(8'h10, 32'd10); wr(8'h14, 32'd3);
    wr(8'h20, 32'd7);  wr(8'h24, 32'd2);
    wr(8'h00, 32'hABCD_0000);
    rd(8'h10, "R2 per0"); rd(8'h14, "R2 duty0");
    rd(8'h20, "R2 per1"); rd(8'h24, "R2 duty1");
    rd(8'h00, "R2 ctrl upper zero");
    chk("R2 ctrl upper", longint'(rdata_o), 0);

    // R4: enable alone or mode alone keeps channels idle
    phase = "R4";
    wr(8'h00, 32'h0000_8001);
    count_level(0, 20, 1'b1, hits);
    chk("R4 en only ch0 / mode only ch1 idle", hits, 0);
    chk("R4 ch1 idle", longint'(pwm_o[1]), 0);

    // R5/R6: normal ch0, inverted ch1
    phase = "R5";
    wr(8'h00, 32'h0000_9181);
    @(negedge clk_i);
    chk("R7 first cycle count 0 active", longint'(pwm_o[0]), 1);
    count_level(0, 30, 1'b1, hits);
    chk("R5 ch0 active cycles in 3 periods", hits, 9);
    phase = "R6";
    count_level(1, 21, 1'b0, hits);
    chk("R6 ch1 low cycles in 3 periods", hits, 6);

    // R10/R11: mid-period updates
    phase = "R10";
    repeat (4) @(negedge clk_i);
    wr(8'h10, 32'd4);
    repeat (3) @(negedge clk_i);
    wr(8'h14, 32'd6);
    phase = "R11";
    wr(8'h20, 32'd5); wr(8'h24, 32'd1);
    repeat (30) @(negedge clk_i);

    // R8: duty beyond period
    phase = "R8";
    wr(8'h14, 32'd9);
    repeat (6) @(negedge clk_i);
    count_level(0, 20, 1'b1, hits);
    chk("R8 ch0 constant active", hits, 20);

    // R9: zero period
    phase = "R9";
    wr(8'h10, 32'd0);
    repeat (6) @(negedge clk_i);
    count_level(0, 20, 1'b1, hits);
    chk("R9 ch0 held idle", hits, 0);
    wr(8'h10, 32'd6); wr(8'h14, 32'd2);

    // R3: unmapped writes ignored, reads zero
    phase = "R3";
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h12, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h08, "R3 read 0x08"); rd(8'h12, "R3 read 0x12");
    rd(8'h30, "R3 read 0x30"); rd(8'h01, "R3 read 0x01");
    rd(8'h00, "R3 ctrl kept"); rd(8'h10, "R3 per0 kept");
    rd(8'h24, "R3 duty1 kept");

    // R7: stop mid-run then restart
    phase = "R7";
    repeat (3) @(negedge clk_i);
    wr(8'h00, 32'h0000_1080);
    count_level(1, 10, 1'b1, hits);
    chk("R7 ch1 idle level high when inverted", hits, 10);
    chk("R7 ch0 idle low", longint'(pwm_o[0]), 0);
    wr(8'h00, 32'h0000_9181);
    repeat (40) @(negedge clk_i);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule